// File: doc/BRIEF.md
# Serial Flash Read Sequencer

The block turns a read request (a start address and a byte count) into a complete read transaction on a serial flash. The transaction has up to four phases, in this order: a command byte, address bytes, dummy clocks and received data bytes. The command phase, the address-and-dummy phase and the data phase each have their own lane width: one, two or four data lines. Received bytes come back one at a time on a valid strobe.

All settings live in one internal configuration word. A single write port loads that word, and only while the sequencer is idle. One bit of the word hands the serial pins either to the sequencer or to an external programmed-I/O engine. When the engine owns the pins, they follow its inputs directly.

The serial clock runs at half the system clock. It idles low. Outgoing bits change on its falling edge, and incoming bits are taken on its rising edge.

Top module: `spi_flash_rd_seq`

## Requirements
- R1: After reset the chip select is high, the serial clock low, all DQ output enables off and `req_ready` high. The configuration defaults to: pins owned by the sequencer, command enabled with value 0x03, 3 address bytes, 0 dummy clocks, pad code 0x00, and every lane width single.
- R2: The configuration word is laid out as follows. [1:0] is the command lane width, [3:2] the address/dummy lane width and [5:4] the data lane width; for each, 0 means one lane, 1 two and 2 four. [6] is command enable, [9:7] the address byte count, [13:10] the dummy clock count, [21:14] the command byte, [29:22] the pad code and [30] pin ownership, where 1 means the sequencer. A write through `cfg_we` takes effect only while idle. A write during a transaction is ignored, both for that transaction and for the ones after it.
- R3: With bit 30 at 0, `sck`, `cs_n`, `dq_o` and `dq_oe` follow the `pio_*` inputs, `req_ready` is low, and a request is ignored.
- R4: When enabled, the command byte is sent MSB first at the command lane width. One lane drives DQ0. Two lanes drive {DQ1,DQ0}, and four lanes drive DQ[3:0], with the earlier bit on the higher line.
- R5: The address phase sends the low min(count,4) bytes of the request address, most significant byte first, at the address lane width. Counts from 5 to 7 act as 4.
- R6: The dummy phase lasts the configured number of serial clocks at the address lane width. It drives the pad code MSB first, then zeros once its 8 bits are used up.
- R7: During the data phase all DQ output enables are off. Bits are taken on each rising edge: from DQ1 with one lane, {DQ1,DQ0} with two and DQ[3:0] with four, with the first bits forming the MSBs. Exactly `req_cnt_m1`+1 bytes are returned, each by a one-cycle `rsp_valid` pulse.
- R8: Each serial clock period lasts two system clocks. The total number of serial clocks in a transaction equals the sum of the clocks of its phases.
- R9: Chip select goes low in the cycle after a request is accepted. It goes high on the same edge that presents the last data byte.
- R10: Empty phases are skipped. With the command disabled and an address count of 0, the transaction starts with the dummy phase, or with the data phase when the dummy count is 0.
- R11: The reserved lane width code 3 behaves as four lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 31 | Configuration word |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_addr | input | ADDR_W | Read start address |
| req_cnt_m1 | input | CNT_W | Number of bytes minus one |
| rsp_valid | output | 1 | Data byte valid pulse |
| rsp_data | output | 8 | Received byte |
| pio_sck | input | 1 | Engine serial clock |
| pio_cs_n | input | 1 | Engine chip select |
| pio_dq_o | input | 4 | Engine DQ output values |
| pio_dq_oe | input | 4 | Engine DQ output enables |
| sck | output | 1 | Serial clock pin |
| cs_n | output | 1 | Chip select pin |
| dq_o | output | 4 | DQ output values |
| dq_oe | output | 4 | DQ output enables |
| dq_i | input | 4 | DQ input values |

## Verification
The hardest state to reach from the ports is a configuration write arriving in the middle of a transaction. The bench reaches it by pulsing the write port a few serial clocks after acceptance, with a word that would remove the command and address phases. It then compares both that transaction and a following one, run without any rewrite, against the earlier settings. A flash model driven from the serial clock supplies a known bit pattern at whichever lane width the test selects. A monitor rebuilds the outgoing bit stream from the lanes enabled on each rising edge, which exposes wrong lane order, wrong phase lengths and skipped phases together.

// File: rtl/spi_flash_rd_seq.sv
module spi_flash_rd_seq #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [30:0]       cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_cnt_m1,
  output logic              rsp_valid,
  output logic [7:0]        rsp_data,
  input  logic              pio_sck,
  input  logic              pio_cs_n,
  input  logic [3:0]        pio_dq_o,
  input  logic [3:0]        pio_dq_oe,
  output logic              sck,
  output logic              cs_n,
  output logic [3:0]        dq_o,
  output logic [3:0]        dq_oe,
  input  logic [3:0]        dq_i
);
  localparam logic [30:0] CFG_RST = 31'h4000_C1C0;

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_ADDR, S_DUM, S_DATA} ph_t;

  function automatic logic [1:0] lsh(input logic [1:0] code);
    return (code == 2'd0) ? 2'd0 : (code == 2'd1) ? 2'd1 : 2'd2;
  endfunction

  ph_t         ph, tgt;
  logic [30:0] cfg;
  logic        sck_r, cs_n_r, rsp_v;
  logic [7:0]  rx, rsp_d, rx_nxt;
  logic [31:0] sh, addr_q, a32, a_src, ld_sh;
  logic [5:0]  cnt, ld_cnt;
  logic [CNT_W-1:0] left;
  logic [1:0]  cw, lc, la, ld;
  logic [2:0]  alen_c;
  logic [3:0]  fl_oe, fl_do;
  logic        busy, fl_en, after_dum;
  ph_t         after_cmd, after_addr, first_ph;

  assign fl_en   = cfg[30];
  assign lc      = lsh(cfg[1:0]);
  assign la      = lsh(cfg[3:2]);
  assign ld      = lsh(cfg[5:4]);
  assign alen_c  = (cfg[9:7] > 3'd4) ? 3'd4 : cfg[9:7];
  assign busy    = (ph != S_IDLE);
  assign a32     = 32'(req_addr);
  assign a_src   = busy ? addr_q : a32;

  assign after_dum  = (cfg[13:10] != 4'd0);
  assign after_addr = after_dum ? S_DUM : S_DATA;
  assign after_cmd  = (alen_c != 3'd0) ? S_ADDR : after_addr;
  assign first_ph   = cfg[6] ? S_CMD : after_cmd;

  always_comb begin
    case (ph)
      S_IDLE:  tgt = first_ph;
      S_CMD:   tgt = after_cmd;
      S_ADDR:  tgt = after_addr;
      default: tgt = S_DATA;
    endcase
    case (tgt)
      S_CMD:  begin ld_sh = {cfg[21:14], 24'd0};            ld_cnt = 6'd8 >> lc; end
      S_ADDR: begin ld_sh = a_src << (6'd8 * (3'd4 - alen_c)); ld_cnt = {alen_c, 3'd0} >> la; end
      S_DUM:  begin ld_sh = {cfg[29:22], 24'd0};            ld_cnt = {2'd0, cfg[13:10]}; end
      default: begin ld_sh = 32'd0;                          ld_cnt = 6'd8 >> ld; end
    endcase
  end

  assign cw = (ph == S_CMD) ? lc : (ph == S_DATA) ? ld : la;

  always_comb begin
    fl_oe = 4'b0000;
    fl_do = 4'b0000;
    if (ph == S_CMD || ph == S_ADDR || ph == S_DUM) begin
      case (cw)
        2'd0:    begin fl_oe = 4'b0001; fl_do = {3'd0, sh[31]};    end
        2'd1:    begin fl_oe = 4'b0011; fl_do = {2'd0, sh[31:30]}; end
        default: begin fl_oe = 4'b1111; fl_do = sh[31:28];         end
      endcase
    end
  end

  always_comb begin
    case (ld)
      2'd0:    rx_nxt = {rx[6:0], dq_i[1]};
      2'd1:    rx_nxt = {rx[5:0], dq_i[1:0]};
      default: rx_nxt = {rx[3:0], dq_i};
    endcase
  end

  assign req_ready = fl_en && !busy && !cfg_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= S_IDLE; cfg <= CFG_RST; sck_r <= 1'b0; cs_n_r <= 1'b1;
      rsp_v <= 1'b0; rsp_d <= 8'd0; rx <= 8'd0; sh <= 32'd0;
      addr_q <= 32'd0; cnt <= 6'd0; left <= '0;
    end else begin
      rsp_v <= 1'b0;
      if (cfg_we && !busy) cfg <= cfg_wdata;
      if (!busy) begin
        if (req_valid && req_ready) begin
          addr_q <= a32;
          left   <= req_cnt_m1;
          cs_n_r <= 1'b0;
          sck_r  <= 1'b0;
          ph     <= tgt;
          sh     <= ld_sh;
          cnt    <= ld_cnt;
        end
      end else if (!sck_r) begin
        sck_r <= 1'b1;
        if (ph == S_DATA) rx <= rx_nxt;
      end else begin
        sck_r <= 1'b0;
        sh    <= sh << (6'd1 << cw);
        cnt   <= cnt - 6'd1;
        if (cnt == 6'd1) begin
          if (ph == S_DATA) begin
            rsp_v <= 1'b1;
            rsp_d <= rx;
            if (left == '0) begin
              ph     <= S_IDLE;
              cs_n_r <= 1'b1;
            end else begin
              left <= left - 1'b1;
              cnt  <= ld_cnt;
            end
          end else begin
            ph  <= tgt;
            sh  <= ld_sh;
            cnt <= ld_cnt;
          end
        end
      end
    end
  end

  assign rsp_valid = rsp_v;
  assign rsp_data  = rsp_d;
  assign sck   = fl_en ? sck_r  : pio_sck;
  assign cs_n  = fl_en ? cs_n_r : pio_cs_n;
  assign dq_o  = fl_en ? fl_do  : pio_dq_o;
  assign dq_oe = fl_en ? fl_oe  : pio_dq_oe;

  // R9
  cs_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !cs_n_r);
  // R9
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_r) |-> rsp_v);
  // R8
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_r |-> !sck_r);
  // R7
  data_oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_v |-> ($past(fl_oe) == 4'b0000));
  // R2
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cfg));
  // R4
  oe_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_oe == 4'b0000 || fl_oe == 4'b0001 || fl_oe == 4'b0011 || fl_oe == 4'b1111));
endmodule

// File: tb/spi_flash_rd_seq_bench.sv
`timescale 1ns/100ps
module spi_flash_rd_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [30:0] cfg_wdata = '0;
  logic req_valid = 1'b0, req_ready;
  logic [31:0] req_addr = '0;
  logic [7:0] req_cnt = '0;
  logic rsp_valid;
  logic [7:0] rsp_data;
  logic pio_sck = 1'b0, pio_cs_n = 1'b1;
  logic [3:0] pio_dq_o = '0, pio_dq_oe = '0;
  logic sck, cs_n;
  logic [3:0] dq_o, dq_oe, dq_i;

  always #2.5 clk = ~clk;

  spi_flash_rd_seq u_spi_flash_rd_seq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_cnt_m1(req_cnt), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .pio_sck(pio_sck), .pio_cs_n(pio_cs_n), .pio_dq_o(pio_dq_o),
    .pio_dq_oe(pio_dq_oe), .sck(sck), .cs_n(cs_n), .dq_o(dq_o),
    .dq_oe(dq_oe), .dq_i(dq_i));

  int n_chk = 0, n_fail = 0;
  bit mon = 0, psck = 0;
  int k = 0, capn = 0, sck_n = 0, data_n = 0, gn = 0, cur_m1 = 0;
  logic [127:0] cap = '0;
  logic [7:0] got [8];
  logic [1:0] cur_dl = 2'd0;
  logic [63:0] pat = '0;

  // {cl,al,dl,cen,alen,dum,code,pad,addr,m1,exp_sck}
  localparam logic [72:0] VEC [9] = '{
    {2'd0,2'd0,2'd0,1'b1,3'd3,4'd0,8'h03,8'h00,32'h00123456,3'd1,8'd48},
    {2'd0,2'd0,2'd0,1'b1,3'd3,4'd8,8'h0B,8'h00,32'h00ABCDEF,3'd0,8'd48},
    {2'd0,2'd0,2'd1,1'b1,3'd3,4'd8,8'h3B,8'h00,32'h00102030,3'd3,8'd56},
    {2'd0,2'd2,2'd2,1'b1,3'd3,4'd4,8'hEB,8'hA5,32'h00C0FFEE,3'd7,8'd34},
    {2'd2,2'd2,2'd2,1'b1,3'd4,4'd6,8'hEC,8'hF0,32'h89ABCDEF,3'd2,8'd22},
    {2'd0,2'd1,2'd1,1'b0,3'd0,4'd3,8'h00,8'hC3,32'h00000000,3'd1,8'd11},
    {2'd0,2'd0,2'd2,1'b0,3'd0,4'd0,8'h00,8'h00,32'h00000000,3'd0,8'd2},
    {2'd1,2'd1,2'd0,1'b1,3'd6,4'd0,8'h5A,8'h00,32'h01020304,3'd0,8'd28},
    {2'd3,2'd3,2'd3,1'b1,3'd1,4'd0,8'h9C,8'h00,32'h00000077,3'd0,8'd6}
  };

  function automatic int w_of(input logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
  endfunction

  task automatic chk(input bit ok, input string r, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  always_comb begin
    logic [63:0] t;
    t = pat << (k * w_of(cur_dl));
    case (w_of(cur_dl))
      1:       dq_i = {2'b00, t[63], 1'b0};
      2:       dq_i = {2'b00, t[63:62]};
      default: dq_i = t[63:60];
    endcase
  end

  always @(negedge clk) begin
    if (mon) begin
      if (sck && !psck) begin
        sck_n++;
        if (dq_oe == 4'b0000) begin
          data_n++;
          if (!cs_n) k++;
        end else if (dq_oe == 4'b0001) begin cap = (cap << 1) | 128'(dq_o[0]);   capn += 1; end
        else if (dq_oe == 4'b0011) begin cap = (cap << 2) | 128'(dq_o[1:0]); capn += 2; end
        else begin cap = (cap << 4) | 128'(dq_o); capn += 4; end
      end
      psck = sck;
      if (rsp_valid) begin
        // R9: chip select rises with the last byte only
        chk(cs_n == (gn == cur_m1), "R9 cs_n at byte", 128'(cs_n), 128'(gn == cur_m1));
        if (gn < 8) got[gn] = rsp_data;
        gn++;
      end
    end
  end

  task automatic wr_cfg(input logic [30:0] c);
    @(negedge clk) cfg_wdata = c; cfg_we = 1'b1;
    @(negedge clk) cfg_we = 1'b0;
  endtask

  task automatic exp_tx(input logic [30:0] c, input logic [31:0] a, output logic [127:0] e, output int n);
    int wa, alen;
    logic [63:0] padv;
    wa = w_of(c[3:2]);
    alen = (c[9:7] > 3'd4) ? 4 : int'(c[9:7]);
    e = '0; n = 0;
    if (c[6]) begin e = (e << 8) | 128'(c[21:14]); n += 8; end
    for (int b = alen - 1; b >= 0; b--) begin e = (e << 8) | 128'((a >> (8 * b)) & 32'hFF); n += 8; end
    padv = {c[29:22], 56'd0};
    for (int d = 0; d < int'(c[13:10]); d++) begin
      e = (e << wa) | 128'(padv >> (64 - wa));
      padv = padv << wa;
      n += wa;
    end
  endtask

  task automatic run_txn(input logic [30:0] c, input bit wr, input logic [31:0] a, input int m1,
                         input int exp_sck, input bit bw, input logic [63:0] p, input string tag);
    logic [127:0] e;
    int en, t, wd;
    if (wr) wr_cfg(c);
    pat = p; cur_dl = c[5:4]; cur_m1 = m1; k = 0; cap = '0; capn = 0;
    sck_n = 0; data_n = 0; gn = 0; psck = 0; mon = 1;
    @(negedge clk) req_addr = a; req_cnt = 8'(m1); req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk) req_valid = 1'b0;
    if (bw) begin
      repeat (3) @(negedge clk);
      cfg_wdata = 31'h4000_0000; cfg_we = 1'b1;
      @(negedge clk) cfg_we = 1'b0;
    end
    t = 0;
    while (!(cs_n && gn > m1) && t < 3000) begin @(negedge clk); t++; end
    @(negedge clk); mon = 0;
    exp_tx(c, a, e, en);
    wd = w_of(c[5:4]);
    // R4 R5 R6 R10 R11: outgoing bit stream
    chk(capn == en, {tag, " R4/R5/R6 tx bit count"}, 128'(capn), 128'(en));
    chk(cap == e, {tag, " R4/R5/R6/R10/R11 tx stream"}, cap, e);
    // R8 R10: serial clock count
    chk(sck_n == exp_sck, {tag, " R8/R10 sck count"}, 128'(sck_n), 128'(exp_sck));
    // R7: data clocks with enables off
    chk(data_n == (m1 + 1) * 8 / wd, {tag, " R7 data clocks"}, 128'(data_n), 128'((m1 + 1) * 8 / wd));
    chk(gn == m1 + 1, {tag, " R7 byte count"}, 128'(gn), 128'(m1 + 1));
    for (int j = 0; j <= m1 && j < 8; j++)
      chk(got[j] == p[63 - 8 * j -: 8], {tag, " R7 data byte"}, 128'(got[j]), 128'(p[63 - 8 * j -: 8]));
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    logic [30:0] c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle pins after reset
    chk(cs_n == 1'b1, "R1 cs_n", 128'(cs_n), 1);
    chk(sck == 1'b0, "R1 sck", 128'(sck), 0);
    chk(dq_oe == 4'b0000, "R1 dq_oe", 128'(dq_oe), 0);
    chk(req_ready == 1'b1, "R1 req_ready", 128'(req_ready), 1);
    // R1: default configuration drives a plain single-lane read
    run_txn(31'h4000_C1C0, 1'b0, 32'h00ABCDEF, 0, 40, 1'b0, 64'h96E1_0F5A_D33C_7B28, "R1 defaults");

    for (int i = 0; i < 9; i++) begin
      c = {1'b1, VEC[i][50:43], VEC[i][58:51], VEC[i][62:59], VEC[i][65:63], VEC[i][66],
           VEC[i][68:67], VEC[i][70:69], VEC[i][72:71]};
      run_txn(c, 1'b1, VEC[i][42:11], int'(VEC[i][10:8]), int'(VEC[i][7:0]), 1'b0,
              64'hD35A_0FE1_963C_7B28 ^ {8{8'(i * 37 + 1)}}, $sformatf("vec%0d", i));
    end

    // R2: a write during a transaction is ignored now and later
    c = {1'b1, 8'h00, 8'h03, 4'd0, 3'd3, 1'b1, 2'd0, 2'd0, 2'd0};
    run_txn(c, 1'b1, 32'h00123456, 1, 48, 1'b1, 64'hA1B2_C3D4_E5F6_0718, "R2 busy write");
    run_txn(c, 1'b0, 32'h00654321, 0, 40, 1'b0, 64'h1122_3344_5566_7788, "R2 after busy write");

    // R3: programmed-I/O engine owns the pins
    wr_cfg(31'h0000_C1C0);
    @(negedge clk) pio_sck = 1'b1; pio_cs_n = 1'b0; pio_dq_o = 4'hA; pio_dq_oe = 4'h5;
    req_valid = 1'b1;
    @(negedge clk);
    chk(sck == 1'b1 && cs_n == 1'b0, "R3 pio sck/cs", 128'({sck, cs_n}), 128'(2'b10));
    chk(dq_o == 4'hA && dq_oe == 4'h5, "R3 pio dq", 128'({dq_o, dq_oe}), 128'(8'hA5));
    chk(req_ready == 1'b0, "R3 req_ready low", 128'(req_ready), 0);
    repeat (4) @(negedge clk);
    req_valid = 1'b0;
    pio_sck = 1'b0; pio_cs_n = 1'b1; pio_dq_oe = 4'h0;
    wr_cfg(31'h4000_C1C0);
    @(negedge clk);
    chk(cs_n == 1'b1 && dq_oe == 4'h0 && req_ready == 1'b1, "R3 request ignored",
        128'({cs_n, dq_oe, req_ready}), 128'({1'b1, 4'h0, 1'b1}));
    finish_run();
  end
endmodule